// File: doc/BRIEF.md
# Interprocessor Mailbox Register Block

A memory-mapped mailbox that lets several processors pass 32-bit words to one another through six small hardware queues. A sender writes a word to a queue's message register and a receiver reads it back from the same address in arrival order. Per-queue status registers report whether a queue is full and how many words it holds, so software can poll instead of waiting for an interrupt.

Each of four users owns an interrupt status word and an interrupt enable word. Both words have two bits per queue: one marks that a word arrived and one marks that a full queue gained a free slot. A user's interrupt line is raised while any enabled status bit is set. Software clears status bits by writing ones to them. A self-timed software reset returns the queues, status bits and enables to their reset values, and a done flag tells software when the block is usable again.

The register bus is plain: one access per cycle, with a byte address, a write strobe, a read strobe and 32-bit data in each direction. There is no valid/ready handshake and no back-pressure. Every access completes in the cycle it is presented. Read data is combinational from the current state, and a read of a message register pops the queue at the end of that cycle.

Top module: `ipc_mailbox`

## Requirements
- R1: The revision register at 0x000 returns the major number in bits 7:4 and the minor number in bits 3:0 (defaults 2 and 1, so it reads 0x21). Any address outside the map, including a message slot for a queue index of 6 or 7, reads zero.
- R2: A write to 0x040 + 4m appends a 32-bit word to queue m. A read of the same address returns and removes the oldest word, so words come back in the order they were written.
- R3: The register at 0x0C0 + 4m reads the number of words held in queue m (0 to 4). The register at 0x080 + 4m reads 1 when queue m holds 4 words and 0 otherwise.
- R4: A write to a full queue is dropped. A read from an empty queue returns zero. Neither access changes the queue's contents or count.
- R5: Status bit 2m is set in every user's status word (at 0x100 + 8u) on each accepted write to queue m. Status bit 2m+1 is set when a read takes queue m from full to not full. Both bits stay set until they are acknowledged.
- R6: Writing a one to a status bit clears it, and the cleared value is visible to a read in the next cycle. Writing a zero leaves the bit unchanged. If an event arrives in the same cycle as its acknowledge, the event wins and the bit stays set.
- R7: irq_out[u] is high exactly when some bit is set in both user u's status word and user u's enable word. The enable word is read/write at 0x104 + 8u.
- R8: Writing 1 to sysconfig (0x010) bit 1 starts a software reset. For the next 8 cycles sysconfig bit 1 reads 1 and sysstatus (0x014) bit 0 reads 0. After that, bit 1 reads 0 and bit 0 reads 1. The reset empties all queues and clears all status and enable bits. Queue and interrupt writes made while the reset runs are ignored.
- R9: Sysconfig bit 0 and bits 4:3 read back the last values written and are kept through a software reset. After a hardware reset they read 0 and sysstatus bit 0 reads 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous hardware reset |
| bus_addr | input | 9 | Byte address of the access; bits 1:0 are ignored |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Read strobe; pops the queue when it addresses a message register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the current address, combinational |
| irq_out | output | 4 | One interrupt line per user |

## Verification
The assertions assume one access per cycle with the write and read strobes never high together, and word-aligned addresses. The queue checks therefore never see a push and a pop to the same queue in the same cycle. The stimulus drives every access through single-strobe tasks that change the inputs only on the falling edge. It reaches the full and empty boundaries of every queue by writing one more word than the depth and reading one more word than was stored. Acknowledges are issued only after the bench has settled the events it expects, except in the one check that deliberately lets a reset overlap bus writes.

// File: rtl/mbox_pkg.sv
`timescale 1ns/1ps
package mbox_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned ADDR_W = 9;
  typedef logic [WORD_W-1:0] word_t;

  // register groups decoded from address bits 8:5
  localparam logic [3:0] GRP_MSG  = 4'h2;  // 0x040
  localparam logic [3:0] GRP_FULL = 4'h4;  // 0x080
  localparam logic [3:0] GRP_CNT  = 4'h6;  // 0x0C0
  localparam logic [3:0] GRP_IRQ  = 4'h8;  // 0x100

  localparam logic [ADDR_W-1:0] OFS_REV    = 9'h000;
  localparam logic [ADDR_W-1:0] OFS_SYSCFG = 9'h010;
  localparam logic [ADDR_W-1:0] OFS_SYSSTS = 9'h014;

  // sysconfig bit positions
  localparam int unsigned CFG_AUTO_BIT = 0;
  localparam int unsigned CFG_SRST_BIT = 1;
  localparam int unsigned CFG_IDLE_LSB = 3;
endpackage

// File: rtl/mbox_queue.sv
`timescale 1ns/1ps
module mbox_queue #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned DW    = 32,
  localparam int unsigned PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] pop_data,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          ev_new,
  output logic          ev_notfull
);
  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic          empty, do_push, do_pop;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  assign full     = (count == CW'(DEPTH));
  assign empty    = (count == '0);
  assign do_push  = push & ~full & ~clr;
  assign do_pop   = pop & ~empty & ~clr;
  assign pop_data = empty ? '0 : mem[rp];
  assign ev_new     = do_push;
  assign ev_notfull = do_pop & full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; count <= '0;
    end else if (clr) begin
      wp <= '0; rp <= '0; count <= '0;
    end else begin
      if (do_push) wp <= nxt(wp);
      if (do_pop)  rp <= nxt(rp);
      count <= count + CW'(do_push) - CW'(do_pop);
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= push_data;
  end

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH)); // R3
  AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    full && push && !pop && !clr |=> count == $past(count)); // R4
  AST_EMPTY_POP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    empty && pop && !push |=> count == '0); // R4
  AST_NOTFULL_LEAVES_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    ev_notfull |=> !full); // R5
endmodule

// File: rtl/mbox_user_irq.sv
`timescale 1ns/1ps
module mbox_user_irq #(
  parameter int unsigned NEV = 12
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clr,
  input  logic [NEV-1:0] events,
  input  logic           ack_we,
  input  logic           en_we,
  input  logic [NEV-1:0] wdata,
  output logic [NEV-1:0] sts,
  output logic [NEV-1:0] en,
  output logic           irq
);
  logic [NEV-1:0] ack_mask;

  assign ack_mask = ack_we ? wdata : '0;
  assign irq      = |(sts & en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts <= '0; en <= '0;
    end else if (clr) begin
      sts <= '0; en <= '0;
    end else begin
      sts <= (sts & ~ack_mask) | events;
      if (en_we) en <= wdata;
    end
  end

  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    ack_we |=> (sts & $past(wdata & ~events)) == '0); // R6
  AST_EVENT_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    (events != '0) && !clr |=> (sts & $past(events)) == $past(events)); // R5
  AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (en != '0) && (sts != '0)); // R7
endmodule

// File: rtl/mbox_srst.sv
`timescale 1ns/1ps
module mbox_srst #(
  parameter int unsigned CYCLES = 8,
  localparam int unsigned CW = $clog2(CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; cnt <= '0;
    end else if (start && !busy) begin
      busy <= 1'b1; cnt <= '0;
    end else if (busy) begin
      cnt <= cnt + CW'(1);
      if (cnt == CW'(CYCLES - 1)) busy <= 1'b0;
    end
  end

  AST_SRST_START: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy); // R8
  AST_SRST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> cnt < CW'(CYCLES)); // R8
endmodule

// File: rtl/ipc_mailbox.sv
`timescale 1ns/1ps
module ipc_mailbox
  import mbox_pkg::*;
#(
  parameter int unsigned NUM_Q       = 6,
  parameter int unsigned NUM_U       = 4,
  parameter int unsigned Q_DEPTH     = 4,
  parameter int unsigned SRST_CYCLES = 8,
  parameter logic [3:0]  REV_MAJOR   = 4'd2,
  parameter logic [3:0]  REV_MINOR   = 4'd1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  output logic [NUM_U-1:0]  irq_out
);
  localparam int unsigned NEV = 2 * NUM_Q;
  localparam int unsigned CW  = $clog2(Q_DEPTH + 1);

  logic [3:0] grp;
  logic [2:0] qi;
  logic [1:0] ui;
  logic       is_en, busy, srst_start;
  logic       cfg_auto;
  logic [1:0] cfg_idle;

  word_t             q_data [NUM_Q];
  logic [CW-1:0]     q_cnt  [NUM_Q];
  logic [NUM_Q-1:0]  q_full, ev_new, ev_nf;
  logic [NEV-1:0]    events;
  logic [NEV-1:0]    u_sts [NUM_U];
  logic [NEV-1:0]    u_en  [NUM_U];

  assign grp   = bus_addr[8:5];
  assign qi    = bus_addr[4:2];
  assign ui    = bus_addr[4:3];
  assign is_en = bus_addr[2];

  assign srst_start = bus_wr && (bus_addr == OFS_SYSCFG) && bus_wdata[CFG_SRST_BIT];

  mbox_srst #(.CYCLES(SRST_CYCLES)) i_srst (
    .clk(clk), .rst_n(rst_n), .start(srst_start), .busy(busy)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_auto <= 1'b0; cfg_idle <= 2'b00;
    end else if (bus_wr && bus_addr == OFS_SYSCFG) begin
      cfg_auto <= bus_wdata[CFG_AUTO_BIT];
      cfg_idle <= bus_wdata[CFG_IDLE_LSB +: 2];
    end
  end

  for (genvar m = 0; m < NUM_Q; m++) begin : g_q
    logic sel;
    assign sel = (grp == GRP_MSG) && (qi == 3'(m));
    mbox_queue #(.DEPTH(Q_DEPTH), .DW(WORD_W)) i_q (
      .clk(clk), .rst_n(rst_n), .clr(busy),
      .push(bus_wr && sel), .push_data(bus_wdata),
      .pop(bus_rd && sel), .pop_data(q_data[m]),
      .count(q_cnt[m]), .full(q_full[m]),
      .ev_new(ev_new[m]), .ev_notfull(ev_nf[m])
    );
    assign events[2*m]   = ev_new[m];
    assign events[2*m+1] = ev_nf[m];
  end

  for (genvar u = 0; u < NUM_U; u++) begin : g_u
    logic sel;
    assign sel = (grp == GRP_IRQ) && (ui == 2'(u));
    mbox_user_irq #(.NEV(NEV)) i_u (
      .clk(clk), .rst_n(rst_n), .clr(busy), .events(events),
      .ack_we(bus_wr && sel && !is_en), .en_we(bus_wr && sel && is_en),
      .wdata(bus_wdata[NEV-1:0]), .sts(u_sts[u]), .en(u_en[u]),
      .irq(irq_out[u])
    );
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == OFS_REV) begin
      bus_rdata[7:0] = {REV_MAJOR, REV_MINOR};
    end else if (bus_addr == OFS_SYSCFG) begin
      bus_rdata[CFG_AUTO_BIT]        = cfg_auto;
      bus_rdata[CFG_SRST_BIT]        = busy;
      bus_rdata[CFG_IDLE_LSB +: 2]   = cfg_idle;
    end else if (bus_addr == OFS_SYSSTS) begin
      bus_rdata[0] = ~busy;
    end else if (32'(qi) < NUM_Q) begin
      if (grp == GRP_MSG)       bus_rdata = q_data[qi];
      else if (grp == GRP_FULL) bus_rdata[0] = q_full[qi];
      else if (grp == GRP_CNT)  bus_rdata[CW-1:0] = q_cnt[qi];
    end
    if ((grp == GRP_IRQ) && (32'(ui) < NUM_U)) begin
      bus_rdata = '0;
      bus_rdata[NEV-1:0] = is_en ? u_en[ui] : u_sts[ui];
    end
  end

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_rd)); // R2
  AST_SRST_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (irq_out == '0) && (q_full == '0)); // R8
endmodule

// File: tb/test_ipc_mailbox.sv
`timescale 1ns/1ps
module test_ipc_mailbox;
  localparam int NQ = 6;
  localparam int NU = 4;
  localparam int DEPTH = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [8:0]  addr = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [3:0]  irq;
  int checks = 0, failures = 0;

  always #10 clk = ~clk;

  ipc_mailbox i_ipc_mailbox (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wr(wr), .bus_rd(rd),
    .bus_wdata(wdata), .bus_rdata(rdata), .irq_out(irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bwr(input logic [8:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(posedge clk); #1 wr = 1'b0;
  endtask

  task automatic brd(input logic [8:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; rd = 1'b1;
    #5 d = rdata;
    @(posedge clk); #1 rd = 1'b0;
  endtask

  function automatic logic [8:0] a_msg(input int m);  return 9'(32'h40 + 4*m); endfunction
  function automatic logic [8:0] a_full(input int m); return 9'(32'h80 + 4*m); endfunction
  function automatic logic [8:0] a_cnt(input int m);  return 9'(32'hC0 + 4*m); endfunction
  function automatic logic [8:0] a_sts(input int u);  return 9'(32'h100 + 8*u); endfunction
  function automatic logic [8:0] a_en(input int u);   return 9'(32'h104 + 8*u); endfunction

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int busy_reads;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 / R9 reset state
    brd(9'h000, d); check("R1 revision", d, 32'h21);
    brd(9'h05C, d); check("R1 unmapped queue slot", d, 0);
    brd(9'h020, d); check("R1 unmapped", d, 0);
    brd(9'h010, d); check("R9 sysconfig reset", d, 0);
    brd(9'h014, d); check("R9 sysstatus reset", d, 1);
    check("R7 irq reset", 32'(irq), 0);

    for (int m = 0; m < NQ; m++) begin
      brd(a_cnt(m), d);  check("R3 empty count", d, 0);
      brd(a_full(m), d); check("R3 not full", d, 0);
      for (int i = 0; i <= DEPTH; i++) begin
        bwr(a_msg(m), 32'hA000_0000 + 32'(m*256 + i));
        brd(a_cnt(m), d);  check("R3 count", d, 32'((i + 1 > DEPTH) ? DEPTH : i + 1));
        brd(a_full(m), d); check("R3 full flag", d, 32'(i + 1 >= DEPTH));
      end
      for (int u = 0; u < NU; u++) begin
        brd(a_sts(u), d); check("R5 new message bit", d, 32'(1) << (2*m));
      end
      for (int i = 0; i < DEPTH; i++) begin
        brd(a_msg(m), d); check("R2 order (R4 drop of last)", d, 32'hA000_0000 + 32'(m*256 + i));
        if (i == 0) begin
          brd(a_sts(m % NU), d);
          check("R5 not-full bit", d, (32'(3) << (2*m)));
        end
      end
      brd(a_msg(m), d); check("R4 empty read zero", d, 0);
      brd(a_cnt(m), d); check("R4 empty count kept", d, 0);
      bwr(a_sts(0), 32'(1) << (2*m));
      brd(a_sts(0), d); check("R6 partial ack", d, 32'(1) << (2*m+1));
      bwr(a_sts(0), 0);
      brd(a_sts(0), d); check("R6 zero write no effect", d, 32'(1) << (2*m+1));
      for (int u = 0; u < NU; u++) bwr(a_sts(u), 32'hFFF);
      brd(a_sts(0), d); check("R6 full ack", d, 0);
    end

    // R7 interrupt masking
    for (int u = 0; u < NU; u++) bwr(a_en(u), 32'(1) << (2*u));
    brd(a_en(2), d); check("R7 enable readback", d, 32'h10);
    bwr(a_msg(0), 32'h11);
    @(negedge clk); check("R7 irq user0", 32'(irq), 32'h1);
    bwr(a_msg(1), 32'h22);
    @(negedge clk); check("R7 irq users0,1", 32'(irq), 32'h3);
    bwr(a_sts(0), 32'h1);
    @(negedge clk); check("R7 irq after ack", 32'(irq), 32'h2);
    bwr(a_en(1), 0);
    @(negedge clk); check("R7 irq after disable", 32'(irq), 32'h0);
    brd(a_msg(0), d); brd(a_msg(1), d);
    for (int u = 0; u < NU; u++) begin bwr(a_sts(u), 32'hFFF); bwr(a_en(u), 0); end

    // R8 software reset
    bwr(a_msg(2), 32'h5); bwr(a_msg(2), 32'h6);
    bwr(a_en(3), 32'hFFF);
    @(negedge clk); check("R7 irq before reset", 32'(irq), 32'h8);
    bwr(9'h010, 32'h1B);
    busy_reads = 0;
    for (int k = 0; k < 12; k++) begin
      brd(9'h014, d);
      if (d[0] == 1'b0) busy_reads++;
    end
    check("R8 reset duration", 32'(busy_reads), 8);
    brd(9'h010, d); check("R9 fields kept, R8 bit1 cleared", d, 32'h19);
    brd(a_cnt(2), d); check("R8 queue emptied", d, 0);
    brd(a_en(3), d);  check("R8 enable cleared", d, 0);
    brd(a_sts(3), d); check("R8 status cleared", d, 0);
    check("R8 irq cleared", 32'(irq), 0);

    // R8 writes ignored while resetting
    bwr(9'h010, 32'h02);
    bwr(a_msg(0), 32'h77);
    bwr(a_en(0), 32'h1);
    repeat (10) @(posedge clk);
    brd(a_cnt(0), d); check("R8 write during reset ignored", d, 0);
    brd(a_en(0), d);  check("R8 enable write during reset ignored", d, 0);
    brd(9'h010, d);   check("R9 fields rewritten", d, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule